// File: doc/BRIEF.md
# I2C Master Register Block with Wishbone Slave Port

This block is the host-facing register bank of an I2C master. A host reaches it through a Wishbone slave port with byte-wide data and a three-bit address. Every access completes in a single cycle. The block holds the values that the serial byte engine next to it needs: a 16-bit clock prescale value, a core enable, an interrupt enable, the byte to transmit and a command word. It reports back the received byte and a status word.

Two address slots have a different meaning for reads and for writes. The data slot takes the transmit byte on a write and returns the received byte on a read. The command/status slot takes a command on a write and returns status on a read. Command bits stay asserted toward the byte engine until that engine reports completion with a one-cycle pulse, and then they clear by themselves. The host therefore writes one command for each start, write, read or stop step.

Top module: `i2cm_regfile`

## Requirements
- R1: A Wishbone access (`wb_stb_i` and `wb_cyc_i` high, `wb_ack_o` low) is acknowledged on the next clock. `wb_ack_o` is never high on two consecutive clocks, so a strobe held high is acknowledged on every other clock.
- R2: Address 0 holds prescale bits 7:0 and address 1 holds bits 15:8. Both read back through the port, and after reset `prescale_o` is 0xFFFF.
- R3: A write to address 0 or 1 while the core is enabled leaves `prescale_o` unchanged.
- R4: Address 2 is the control register. Bit 7 is the core enable (`core_en_o`) and bit 6 is the interrupt enable. Bits 5:0 are not implemented and read as zero.
- R5: A write to address 3 loads `tx_byte_o`. A read of address 3 returns `rx_byte_i`.
- R6: A write to address 4 loads the command: bit 7 start, bit 6 stop, bit 5 read, bit 4 write, bit 3 send-NACK. A read of address 4 returns status: bit 7 `rx_nack_i`, bit 6 `bus_busy_i`, bit 1 transfer in progress (a read or write command is pending), bit 0 interrupt flag. The other status bits are zero.
- R7: The clock after an `op_done_i` pulse, all command outputs are low, unless a command write is committed in that same cycle.
- R8: While the core is disabled, command writes are ignored and any pending command bits are cleared on the next clock.
- R9: `op_done_i` sets the interrupt flag. Writing a command with bit 0 set clears it, and a set has priority over a clear. `irq_o` is the flag gated by the interrupt enable.
- R10: The parameter `RST_ACTIVE_HIGH` selects the polarity of `arst_i` for every register in the block. After reset, all registers are zero except the prescale value.
- R11: Reads of addresses 5 to 7 return zero, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| arst_i | input | 1 | Asynchronous reset, polarity set by parameter |
| wb_adr_i | input | ADR_W | Register address |
| wb_dat_i | input | DATA_W | Write data |
| wb_we_i | input | 1 | Write enable |
| wb_stb_i | input | 1 | Strobe |
| wb_cyc_i | input | 1 | Cycle valid |
| wb_dat_o | output | DATA_W | Read data, valid with acknowledge |
| wb_ack_o | output | 1 | Acknowledge |
| prescale_o | output | 2*DATA_W | Prescale value to the clock divider |
| core_en_o | output | 1 | Core enable |
| irq_o | output | 1 | Interrupt request |
| tx_byte_o | output | DATA_W | Byte to transmit |
| cmd_start_o | output | 1 | Start command pending |
| cmd_stop_o | output | 1 | Stop command pending |
| cmd_read_o | output | 1 | Read command pending |
| cmd_write_o | output | 1 | Write command pending |
| cmd_nack_o | output | 1 | Send NACK after the read byte |
| op_done_i | input | 1 | One-cycle completion pulse from the byte engine |
| rx_byte_i | input | DATA_W | Received byte |
| rx_nack_i | input | 1 | SDA value sampled in the ninth clock |
| bus_busy_i | input | 1 | Bus busy |

## Verification
Five properties are checked on every clock: the one-clock acknowledge and its non-repetition, the prescale value staying frozen while the core is enabled, command bits dropping after a completion pulse, and command bits staying clear while the core is disabled. The decoding of addresses into their registers, the split meaning of the shared read/write slots, the zero-filled unused bits, the interrupt set-and-clear sequence and the reset values can only be shown by the bench's scenarios, which compare read data against expected values queued by the driver.

// File: rtl/i2cm_reg_pkg.sv
package i2cm_reg_pkg;
  localparam int unsigned ADR_PRE_LO = 0;
  localparam int unsigned ADR_PRE_HI = 1;
  localparam int unsigned ADR_CTRL   = 2;
  localparam int unsigned ADR_DATA   = 3;
  localparam int unsigned ADR_CMDST  = 4;
  localparam int unsigned NUM_REGS   = 5;

  // control bit positions
  localparam int unsigned CTRL_EN  = 7;
  localparam int unsigned CTRL_IEN = 6;
  // command bit positions
  localparam int unsigned CMD_STA  = 7;
  localparam int unsigned CMD_STO  = 6;
  localparam int unsigned CMD_RD   = 5;
  localparam int unsigned CMD_WR   = 4;
  localparam int unsigned CMD_NACK = 3;
  localparam int unsigned CMD_IACK = 0;
  // status bit positions
  localparam int unsigned ST_RXNACK = 7;
  localparam int unsigned ST_BUSY   = 6;
  localparam int unsigned ST_TIP    = 1;
  localparam int unsigned ST_IRQ    = 0;

  typedef struct packed {
    logic sta;
    logic sto;
    logic rd;
    logic wr;
    logic nack;
  } cmd_t;
endpackage

// File: rtl/i2cm_wb_port.sv
module i2cm_wb_port (
  input  logic clk_i,
  input  logic rst_i,
  input  logic stb_i,
  input  logic cyc_i,
  input  logic we_i,
  output logic ack_o,
  output logic wr_o,
  output logic rd_o
);
  logic ack_q;
  logic access;

  assign access = stb_i & cyc_i & ~ack_q;
  assign wr_o   = access & we_i;
  assign rd_o   = access & ~we_i;
  assign ack_o  = ack_q;

  always_ff @(posedge clk_i or posedge rst_i) begin
    if (rst_i) ack_q <= 1'b0;
    else       ack_q <= access;
  end
endmodule

// File: rtl/i2cm_cfg_regs.sv
module i2cm_cfg_regs #(
  parameter int unsigned DATA_W = 8
) (
  input  logic                clk_i,
  input  logic                rst_i,
  input  logic                wr_pre_lo_i,
  input  logic                wr_pre_hi_i,
  input  logic                wr_ctrl_i,
  input  logic                wr_data_i,
  input  logic [DATA_W-1:0]   wdat_i,
  output logic [2*DATA_W-1:0] prescale_o,
  output logic                en_o,
  output logic                ien_o,
  output logic [DATA_W-1:0]   tx_o
);
  import i2cm_reg_pkg::*;

  logic [DATA_W-1:0] pre_lo_q, pre_hi_q, tx_q;
  logic              en_q, ien_q;

  always_ff @(posedge clk_i or posedge rst_i) begin
    if (rst_i) begin
      pre_lo_q <= '1;
      pre_hi_q <= '1;
      en_q     <= 1'b0;
      ien_q    <= 1'b0;
      tx_q     <= '0;
    end else begin
      // prescale frozen while the core runs
      if (wr_pre_lo_i && !en_q) pre_lo_q <= wdat_i;
      if (wr_pre_hi_i && !en_q) pre_hi_q <= wdat_i;
      if (wr_ctrl_i) begin
        en_q  <= wdat_i[CTRL_EN];
        ien_q <= wdat_i[CTRL_IEN];
      end
      if (wr_data_i) tx_q <= wdat_i;
    end
  end

  assign prescale_o = {pre_hi_q, pre_lo_q};
  assign en_o       = en_q;
  assign ien_o      = ien_q;
  assign tx_o       = tx_q;
endmodule

// File: rtl/i2cm_cmd_stat.sv
module i2cm_cmd_stat #(
  parameter int unsigned DATA_W = 8
) (
  input  logic                clk_i,
  input  logic                rst_i,
  input  logic                wr_cmd_i,
  input  logic [DATA_W-1:0]   wdat_i,
  input  logic                en_i,
  input  logic                done_i,
  output i2cm_reg_pkg::cmd_t  cmd_o,
  output logic                irq_flag_o
);
  import i2cm_reg_pkg::*;

  cmd_t cmd_q;
  logic irq_q;
  cmd_t cmd_new;

  always_comb begin
    cmd_new.sta  = wdat_i[CMD_STA];
    cmd_new.sto  = wdat_i[CMD_STO];
    cmd_new.rd   = wdat_i[CMD_RD];
    cmd_new.wr   = wdat_i[CMD_WR];
    cmd_new.nack = wdat_i[CMD_NACK];
  end

  always_ff @(posedge clk_i or posedge rst_i) begin
    if (rst_i) begin
      cmd_q <= '0;
      irq_q <= 1'b0;
    end else begin
      if (!en_i)         cmd_q <= '0;
      else if (wr_cmd_i) cmd_q <= cmd_new;
      else if (done_i)   cmd_q <= '0;

      if (done_i)                              irq_q <= 1'b1;
      else if (wr_cmd_i && wdat_i[CMD_IACK])   irq_q <= 1'b0;
    end
  end

  assign cmd_o      = cmd_q;
  assign irq_flag_o = irq_q;
endmodule

// File: rtl/i2cm_regfile.sv
module i2cm_regfile #(
  parameter int unsigned ADR_W           = 3,
  parameter int unsigned DATA_W          = 8,
  parameter bit          RST_ACTIVE_HIGH = 1'b1
) (
  input  logic                clk_i,
  input  logic                arst_i,
  input  logic [ADR_W-1:0]    wb_adr_i,
  input  logic [DATA_W-1:0]   wb_dat_i,
  input  logic                wb_we_i,
  input  logic                wb_stb_i,
  input  logic                wb_cyc_i,
  output logic [DATA_W-1:0]   wb_dat_o,
  output logic                wb_ack_o,
  output logic [2*DATA_W-1:0] prescale_o,
  output logic                core_en_o,
  output logic                irq_o,
  output logic [DATA_W-1:0]   tx_byte_o,
  output logic                cmd_start_o,
  output logic                cmd_stop_o,
  output logic                cmd_read_o,
  output logic                cmd_write_o,
  output logic                cmd_nack_o,
  input  logic                op_done_i,
  input  logic [DATA_W-1:0]   rx_byte_i,
  input  logic                rx_nack_i,
  input  logic                bus_busy_i
);
  import i2cm_reg_pkg::*;

  localparam int unsigned SLOTS = 1 << ADR_W;

  logic                rst;
  logic                wr_acc, rd_acc;
  logic [SLOTS-1:0]    wsel;
  logic                ien, irq_flag;
  cmd_t                cmd;
  logic [DATA_W-1:0]   ctrl_rd, stat_rd, rd_mux;
  logic [DATA_W-1:0]   dat_q;

  assign rst = RST_ACTIVE_HIGH ? arst_i : ~arst_i;

  i2cm_wb_port u_port (
    .clk_i (clk_i),
    .rst_i (rst),
    .stb_i (wb_stb_i),
    .cyc_i (wb_cyc_i),
    .we_i  (wb_we_i),
    .ack_o (wb_ack_o),
    .wr_o  (wr_acc),
    .rd_o  (rd_acc)
  );

  for (genvar g = 0; g < SLOTS; g++) begin : g_dec
    assign wsel[g] = wr_acc && (wb_adr_i == ADR_W'(g));
  end

  i2cm_cfg_regs #(.DATA_W(DATA_W)) u_cfg (
    .clk_i       (clk_i),
    .rst_i       (rst),
    .wr_pre_lo_i (wsel[ADR_PRE_LO]),
    .wr_pre_hi_i (wsel[ADR_PRE_HI]),
    .wr_ctrl_i   (wsel[ADR_CTRL]),
    .wr_data_i   (wsel[ADR_DATA]),
    .wdat_i      (wb_dat_i),
    .prescale_o  (prescale_o),
    .en_o        (core_en_o),
    .ien_o       (ien),
    .tx_o        (tx_byte_o)
  );

  i2cm_cmd_stat #(.DATA_W(DATA_W)) u_cmd (
    .clk_i      (clk_i),
    .rst_i      (rst),
    .wr_cmd_i   (wsel[ADR_CMDST]),
    .wdat_i     (wb_dat_i),
    .en_i       (core_en_o),
    .done_i     (op_done_i),
    .cmd_o      (cmd),
    .irq_flag_o (irq_flag)
  );

  always_comb begin
    ctrl_rd           = '0;
    ctrl_rd[CTRL_EN]  = core_en_o;
    ctrl_rd[CTRL_IEN] = ien;
    stat_rd            = '0;
    stat_rd[ST_RXNACK] = rx_nack_i;
    stat_rd[ST_BUSY]   = bus_busy_i;
    stat_rd[ST_TIP]    = cmd.rd | cmd.wr;
    stat_rd[ST_IRQ]    = irq_flag;
    unique case (int'(wb_adr_i))
      ADR_PRE_LO: rd_mux = prescale_o[DATA_W-1:0];
      ADR_PRE_HI: rd_mux = prescale_o[2*DATA_W-1:DATA_W];
      ADR_CTRL:   rd_mux = ctrl_rd;
      ADR_DATA:   rd_mux = rx_byte_i;
      ADR_CMDST:  rd_mux = stat_rd;
      default:    rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk_i or posedge rst) begin
    if (rst)         dat_q <= '0;
    else if (rd_acc) dat_q <= rd_mux;
  end

  assign wb_dat_o    = dat_q;
  assign irq_o       = irq_flag & ien;
  assign cmd_start_o = cmd.sta;
  assign cmd_stop_o  = cmd.sto;
  assign cmd_read_o  = cmd.rd;
  assign cmd_write_o = cmd.wr;
  assign cmd_nack_o  = cmd.nack;
endmodule

// File: rtl/i2cm_regfile_chk.sv
module i2cm_regfile_chk #(
  parameter int unsigned ADR_W           = 3,
  parameter int unsigned DATA_W          = 8,
  parameter bit          RST_ACTIVE_HIGH = 1'b1
) (
  input logic                clk_i,
  input logic                arst_i,
  input logic [ADR_W-1:0]    wb_adr_i,
  input logic                wb_we_i,
  input logic                wb_stb_i,
  input logic                wb_cyc_i,
  input logic                wb_ack_o,
  input logic [2*DATA_W-1:0] prescale_o,
  input logic                core_en_o,
  input logic                cmd_start_o,
  input logic                cmd_stop_o,
  input logic                cmd_read_o,
  input logic                cmd_write_o,
  input logic                op_done_i
);
  logic rst;
  logic cmd_wr_commit;
  logic any_cmd;
  assign rst = RST_ACTIVE_HIGH ? arst_i : ~arst_i;
  assign cmd_wr_commit = wb_stb_i && wb_cyc_i && !wb_ack_o && wb_we_i && (wb_adr_i == ADR_W'(4));
  assign any_cmd = cmd_start_o | cmd_stop_o | cmd_read_o | cmd_write_o;

  AST_ACK_NEXT: assert property (@(posedge clk_i) disable iff (rst) (wb_stb_i && wb_cyc_i && !wb_ack_o) |=> wb_ack_o); // R1
  AST_ACK_SINGLE: assert property (@(posedge clk_i) disable iff (rst) wb_ack_o |=> !wb_ack_o); // R1
  AST_PRESCALE_FROZEN: assert property (@(posedge clk_i) disable iff (rst) core_en_o |=> $stable(prescale_o)); // R3
  AST_CMD_SELF_CLEAR: assert property (@(posedge clk_i) disable iff (rst) (op_done_i && !cmd_wr_commit) |=> !any_cmd); // R7
  AST_CMD_IDLE_WHEN_OFF: assert property (@(posedge clk_i) disable iff (rst) !core_en_o |=> !any_cmd); // R8
endmodule

bind i2cm_regfile i2cm_regfile_chk #(
  .ADR_W(ADR_W), .DATA_W(DATA_W), .RST_ACTIVE_HIGH(RST_ACTIVE_HIGH)
) u_chk (
  .clk_i(clk_i), .arst_i(arst_i), .wb_adr_i(wb_adr_i), .wb_we_i(wb_we_i),
  .wb_stb_i(wb_stb_i), .wb_cyc_i(wb_cyc_i), .wb_ack_o(wb_ack_o),
  .prescale_o(prescale_o), .core_en_o(core_en_o), .cmd_start_o(cmd_start_o),
  .cmd_stop_o(cmd_stop_o), .cmd_read_o(cmd_read_o), .cmd_write_o(cmd_write_o),
  .op_done_i(op_done_i)
);

// File: tb/i2cm_regfile_tb_top.sv
`timescale 1ns/1ps
module i2cm_regfile_tb_top;
  localparam int unsigned ADR_W = 3;
  localparam int unsigned DATA_W = 8;
  localparam bit RST_HI = 1'b1;

  logic clk = 1'b0;
  logic arst;
  logic [ADR_W-1:0] adr = '0;
  logic [DATA_W-1:0] wdat = '0;
  logic we = 1'b0, stb = 1'b0, cyc = 1'b0;
  logic [DATA_W-1:0] rdat;
  logic ack;
  logic [2*DATA_W-1:0] presc;
  logic en, irq;
  logic [DATA_W-1:0] txb;
  logic c_sta, c_sto, c_rd, c_wr, c_nack;
  logic done = 1'b0;
  logic [DATA_W-1:0] rxb = '0;
  logic rxnack = 1'b0, busy = 1'b0;

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;
  logic [DATA_W-1:0] exp_q[$];
  string tag_q[$];

  always #5 clk = ~clk;

  i2cm_regfile #(.ADR_W(ADR_W), .DATA_W(DATA_W), .RST_ACTIVE_HIGH(RST_HI)) dut_i (
    .clk_i(clk), .arst_i(arst), .wb_adr_i(adr), .wb_dat_i(wdat), .wb_we_i(we),
    .wb_stb_i(stb), .wb_cyc_i(cyc), .wb_dat_o(rdat), .wb_ack_o(ack),
    .prescale_o(presc), .core_en_o(en), .irq_o(irq), .tx_byte_o(txb),
    .cmd_start_o(c_sta), .cmd_stop_o(c_sto), .cmd_read_o(c_rd),
    .cmd_write_o(c_wr), .cmd_nack_o(c_nack), .op_done_i(done),
    .rx_byte_i(rxb), .rx_nack_i(rxnack), .bus_busy_i(busy)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // monitor: compare each read acknowledge against the scoreboard queue
  always @(posedge clk) begin
    #1;
    if (ack && !we && stb) begin
      if (exp_q.size() == 0) begin
        checks++; fails++;
        $display("FAIL R1 unexpected read ack actual=%0h expected=none", rdat);
      end else begin
        logic [DATA_W-1:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(t, 32'(rdat), 32'(e));
      end
    end
  end

  task automatic do_reset();
    @(negedge clk);
    arst = RST_HI;
    repeat (2) @(negedge clk);
    arst = ~RST_HI;
  endtask

  task automatic wb_write(input int a, input logic [7:0] d);
    @(negedge clk);
    adr = ADR_W'(a); wdat = d; we = 1'b1; stb = 1'b1; cyc = 1'b1;
    @(posedge clk);
    @(negedge clk);
    stb = 1'b0; cyc = 1'b0; we = 1'b0;
  endtask

  task automatic wb_read(input int a, input logic [7:0] e, input string t);
    exp_q.push_back(e);
    tag_q.push_back(t);
    @(negedge clk);
    adr = ADR_W'(a); we = 1'b0; stb = 1'b1; cyc = 1'b1;
    @(posedge clk);
    @(negedge clk);
    stb = 1'b0; cyc = 1'b0;
  endtask

  task automatic pulse_done();
    @(negedge clk);
    done = 1'b1;
    @(negedge clk);
    done = 1'b0;
  endtask

  initial begin
    #(200000 * 10);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    arst = RST_HI;
    repeat (3) @(negedge clk);
    arst = ~RST_HI;

    // R10 reset values
    chk("R10 prescale", 32'(presc), 32'hFFFF);
    chk("R10 enable", 32'(en), 0);
    chk("R10 cmd", 32'({c_sta, c_sto, c_rd, c_wr, c_nack}), 0);
    wb_read(0, 8'hFF, "R2 lo reset");
    wb_read(1, 8'hFF, "R2 hi reset");
    wb_read(2, 8'h00, "R10 ctrl reset");
    wb_read(4, 8'h00, "R10 status reset");

    // R2 prescale programming
    wb_write(0, 8'h34);
    wb_write(1, 8'h12);
    chk("R2 prescale out", 32'(presc), 32'h1234);
    wb_read(0, 8'h34, "R2 lo readback");
    wb_read(1, 8'h12, "R2 hi readback");

    // R8 command ignored while disabled
    wb_write(4, 8'h20);
    chk("R8 cmd ignored", 32'(c_rd), 0);

    // R4 control
    wb_write(2, 8'hFF);
    wb_read(2, 8'hC0, "R4 unused bits zero");
    chk("R4 enable out", 32'(en), 1);

    // R3 prescale frozen
    wb_write(0, 8'h55);
    wb_write(1, 8'h66);
    chk("R3 prescale locked", 32'(presc), 32'h1234);

    // R5 data slot
    wb_write(3, 8'hA5);
    chk("R5 tx byte", 32'(txb), 32'hA5);
    rxb = 8'h3C;
    wb_read(3, 8'h3C, "R5 rx byte");

    // R6 command and status
    busy = 1'b1; rxnack = 1'b1;
    wb_write(4, 8'h98);
    chk("R6 cmd outputs", 32'({c_sta, c_sto, c_rd, c_wr, c_nack}), 32'b10011);
    wb_read(4, 8'hC2, "R6 status tip");
    wb_write(4, 8'h60);
    chk("R6 stop+read", 32'({c_sta, c_sto, c_rd, c_wr, c_nack}), 32'b01100);

    // R7 self clear, R9 interrupt
    pulse_done();
    chk("R7 cmd cleared", 32'({c_sta, c_sto, c_rd, c_wr, c_nack}), 0);
    chk("R9 irq asserted", 32'(irq), 1);
    busy = 1'b0; rxnack = 1'b0;
    wb_read(4, 8'h01, "R9 status irq flag");
    wb_write(2, 8'h80);
    chk("R9 irq masked", 32'(irq), 0);
    wb_write(2, 8'hC0);
    chk("R9 irq unmasked", 32'(irq), 1);
    wb_write(4, 8'h01);
    chk("R9 irq acked", 32'(irq), 0);
    wb_read(4, 8'h00, "R9 status cleared");

    // R8 pending command cleared on disable
    wb_write(4, 8'h10);
    chk("R8 cmd pending", 32'(c_wr), 1);
    wb_write(2, 8'h00);
    @(negedge clk);
    chk("R8 cmd dropped", 32'(c_wr), 0);

    // R11 unmapped slots
    wb_write(5, 8'hFF);
    wb_write(7, 8'hFF);
    wb_read(6, 8'h00, "R11 unmapped read");
    wb_read(2, 8'h00, "R11 ctrl untouched");
    wb_read(0, 8'h34, "R11 prescale untouched");

    // R1 held strobe: ack pattern 1,0,1
    @(negedge clk);
    adr = 3'd5; we = 1'b1; wdat = 8'h00; stb = 1'b1; cyc = 1'b1;
    @(posedge clk); #1 chk("R1 ack first", 32'(ack), 1);
    @(posedge clk); #1 chk("R1 ack gap", 32'(ack), 0);
    @(posedge clk); #1 chk("R1 ack again", 32'(ack), 1);
    @(negedge clk);
    stb = 1'b0; cyc = 1'b0; we = 1'b0;
    @(posedge clk); #1 chk("R1 ack idle", 32'(ack), 0);

    // R10 reset mid-run
    wb_write(2, 8'h80);
    do_reset();
    chk("R10 prescale after reset", 32'(presc), 32'h1234 ^ 32'h1234 ^ 32'hFFFF);
    chk("R10 enable after reset", 32'(en), 0);

    repeat (3) @(negedge clk);
    chk("R1 all reads acked", 32'(exp_q.size()), 0);
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule